// File: doc/BRIEF.md
# Shared Colour Lookup Palette with CPU Access Arbitration

This block holds a 256-entry colour lookup table that two masters share. The display pipeline presents an 8-bit pixel index on every pixel clock and gets back a 32-bit colour word one cycle later. The colour word holds red in bits 23:16, green in bits 15:8 and blue in bits 7:0, and its upper byte is zero. The CPU reaches the same table through a simple register port. Before it may change entries, it must raise a request bit in a control register and poll a grant bit.

Access is granted only while the display is in vertical blanking or switched off, so a change made by the CPU never tears a visible line. Once the grant is given, the CPU keeps it until it drops its request, even if active video resumes. During that time the display side is served the last colour it fetched. Stored colours keep only the significant bits of a 5-6-5 format, and the rest of each word is forced to zero.

The display interface carries only a valid signal and no ready signal. Every index presented with `pix_valid` is accepted in that cycle, and exactly one result leaves the block one cycle later. Neither side of the display path can apply back-pressure.

Top module: `clut_share`

## Requirements
- R1: After reset, the request bit, the grant bit and `col_valid` are all 0.
- R2: A palette write stores `wdata & 32'h00F8FCF8`: red bits 23:19, green bits 15:10 and blue bits 7:3 are kept, and every other bit becomes 0.
- R3: The grant (control register bit 4) rises only while the request bit is set and either `vblank` is 1 or `disp_on` is 0. A request made during active video with the display on stays ungranted for as long as those conditions hold.
- R4: Once set, the grant stays set for as long as the request stays set, even after blanking ends. Clearing the request clears the grant on the next clock.
- R5: A CPU write to a palette entry while the grant is 0 leaves the entry unchanged.
- R6: A CPU read of a palette entry returns the stored masked word when granted, and returns 0 when not granted.
- R7: When `pix_valid` is 1 with index `pix_idx` and no grant is held, `col_valid` is 1 in the next cycle and `col_data` holds entry `pix_idx`. `col_valid` follows `pix_valid` with one cycle of delay in every case.
- R8: While the grant is held, `col_data` does not change, whatever indices the display presents.
- R9: When `cpu_addr[10]` is 0, the CPU addresses palette entry `cpu_addr[9:2]`, and `cpu_addr[1:0]` is ignored. When `cpu_addr[10]` is 1, the CPU addresses the control register.
- R10: In the control register, bit 0 is the request and can be read and written. Bit 4 is the grant and is read-only, so writing to it has no effect. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vblank | input | 1 | Display is in vertical blanking |
| disp_on | input | 1 | Display is enabled |
| cpu_sel | input | 1 | CPU access strobe |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 11 | CPU byte address (bit 10 selects the control register) |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data, combinational |
| pix_valid | input | 1 | Display index valid |
| pix_idx | input | 8 | Display palette index |
| col_valid | output | 1 | Colour result valid |
| col_data | output | 32 | Colour result, xRGB |

## Verification
Palette contents are filled with random words, and the stored values are read back through both ports. This separates correct masking and indexing from simple pass-through. Random display index streams are run while no grant is held, to show that the read path is live. The same streams are then run while the grant is held, which tells the hold behaviour apart from a live read. Directed cases cover a request made during active video, the grant surviving the end of blanking, writes made without a grant, aliased low address bits, and attempts to write the read-only grant bit.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam logic [31:0] CLUT_KEEP_MASK = 32'h00F8FCF8;
  localparam int CTL_REQ_BIT = 0;
  localparam int CTL_GNT_BIT = 4;
endpackage

// File: rtl/clut_grant.sv
module clut_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_req_in,
  input  logic vblank,
  input  logic disp_on,
  output logic req,
  output logic grant
);
  logic quiet;
  assign quiet = vblank | ~disp_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req   <= 1'b0;
      grant <= 1'b0;
    end else begin
      if (ctl_wr) req <= ctl_req_in;
      grant <= req & (grant | quiet);
    end
  end

  // R3: grant only rises on a request seen in a quiet display period
  a_r3_grant_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(req && (vblank || !disp_on)));
  // R4: grant drops the cycle after the request is gone
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !grant);
  // R4: grant persists while request stays
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && req) |=> grant);
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEEP = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  cpu_idx,
  output logic [DATA_W-1:0] cpu_word,
  input  logic              hold,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic              col_valid,
  output logic [DATA_W-1:0] col_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data & KEEP;
  end

  assign cpu_word = mem[cpu_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_valid <= 1'b0;
      col_data  <= '0;
    end else begin
      col_valid <= pix_valid;
      if (pix_valid && !hold) col_data <= mem[pix_idx];
    end
  end

  // R7: one result per accepted index, one cycle later
  a_r7_one_per_index: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> col_valid);
  // R8: colour frozen while the CPU owns the table
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold) |-> $stable(col_data));
endmodule

// File: rtl/clut_share.sv
module clut_share #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vblank,
  input  logic              disp_on,
  input  logic              cpu_sel,
  input  logic              cpu_we,
  input  logic [IDX_W+2:0]  cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic              col_valid,
  output logic [DATA_W-1:0] col_data
);
  import clut_pkg::*;
  localparam int ADDR_W = IDX_W + 3;
  localparam int CTL_SEL_BIT = ADDR_W - 1;

  logic is_ctl, req, grant, pal_wr;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] pal_word, ctl_word;

  assign is_ctl = cpu_addr[CTL_SEL_BIT];
  assign idx    = cpu_addr[IDX_W+1:2];
  assign pal_wr = cpu_sel & cpu_we & ~is_ctl & grant;

  clut_grant u_grant (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (cpu_sel & cpu_we & is_ctl),
    .ctl_req_in(cpu_wdata[CTL_REQ_BIT]),
    .vblank    (vblank),
    .disp_on   (disp_on),
    .req       (req),
    .grant     (grant)
  );

  clut_store #(
    .IDX_W (IDX_W),
    .DATA_W(DATA_W),
    .KEEP  (DATA_W'(CLUT_KEEP_MASK))
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (pal_wr),
    .wr_idx   (idx),
    .wr_data  (cpu_wdata),
    .cpu_idx  (idx),
    .cpu_word (pal_word),
    .hold     (grant),
    .pix_valid(pix_valid),
    .pix_idx  (pix_idx),
    .col_valid(col_valid),
    .col_data (col_data)
  );

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_REQ_BIT] = req;
    ctl_word[CTL_GNT_BIT] = grant;
    if (!cpu_sel)    cpu_rdata = '0;
    else if (is_ctl) cpu_rdata = ctl_word;
    else             cpu_rdata = grant ? pal_word : '0;
  end

  // R2/R6: granted palette reads never expose masked-off bits
  a_r2_masked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && !is_ctl && grant) |-> ((cpu_rdata & ~DATA_W'(CLUT_KEEP_MASK)) == '0));
  // R6: ungranted palette reads return zero
  a_r6_zero_ungranted: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_sel && !is_ctl && !grant) |-> (cpu_rdata == '0));
endmodule

// File: tb/clut_share_tb_top.sv
module clut_share_tb_top;
  logic clk = 0, rst_n = 0;
  logic vblank = 0, disp_on = 1;
  logic cpu_sel = 0, cpu_we = 0;
  logic [10:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic pix_valid = 0;
  logic [7:0] pix_idx = '0;
  logic col_valid;
  logic [31:0] col_data;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [31:0] model [256];

  always #2.5 clk = ~clk;

  clut_share dut_i (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] keep(input logic [31:0] d);
    return {8'h00, d[23:19], 3'b000, d[15:10], 2'b00, d[7:3], 3'b000};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 0; cpu_we = 0;
  endtask

  task automatic cpu_rd(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_sel = 1; cpu_we = 0; cpu_addr = a;
    #1 d = cpu_rdata;
    cpu_sel = 0;
  endtask

  task automatic pix(input logic [7:0] i, output logic [31:0] d, output logic v);
    @(negedge clk);
    pix_valid = 1; pix_idx = i;
    @(negedge clk);
    pix_valid = 0;
    d = col_data; v = col_valid;
  endtask

  task automatic get_grant();
    logic [31:0] r;
    vblank = 1;
    cpu_wr(11'h400, 32'h1);
    repeat (2) @(negedge clk);
    cpu_rd(11'h400, r);
    check("R3 grant in blanking", r, 32'h11);
    vblank = 0;
  endtask

  task automatic drop_grant();
    logic [31:0] r;
    cpu_wr(11'h400, 32'h0);
    @(negedge clk);
    cpu_rd(11'h400, r);
    check("R4 grant cleared", r, 32'h0);
  endtask

  initial begin
    logic [31:0] r, d, last;
    logic v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    cpu_rd(11'h400, r);
    check("R1 reset ctl", r, 32'h0);
    check("R1 reset col_valid", {31'b0, col_valid}, 32'h0);
    rst_n = 1;

    // R3: request during active video stays ungranted
    cpu_wr(11'h400, 32'h1);
    repeat (10) @(negedge clk);
    cpu_rd(11'h400, r);
    check("R3 no grant in active", r, 32'h1);
    // R10: writing read-only grant bit has no effect
    cpu_wr(11'h400, 32'h10);
    @(negedge clk);
    cpu_rd(11'h400, r);
    check("R10 grant bit read-only", r, 32'h0);
    // R3: display off grants
    disp_on = 0;
    cpu_wr(11'h400, 32'h1);
    repeat (2) @(negedge clk);
    cpu_rd(11'h400, r);
    check("R3 grant display off", r, 32'h11);
    disp_on = 1;
    drop_grant();

    // Fill palette with random words (R2)
    get_grant();
    for (int i = 0; i < 256; i++) begin
      d = $urandom;
      if (i == 7) d = 32'hFFFF_FFFF;
      model[i] = keep(d);
      cpu_wr({1'b0, i[7:0], 2'b00}, d);
    end
    // R4: grant held after blanking ended
    cpu_rd(11'h400, r);
    check("R4 grant held after blank", r, 32'h11);
    for (int k = 0; k < 20; k++) begin
      int i = $urandom_range(255);
      cpu_rd({1'b0, i[7:0], 2'b00}, r);
      check("R2 masked readback", r, model[i]);
    end
    cpu_rd(11'h01C, r);
    check("R2 all-ones mask", r, 32'h00F8FCF8);
    // R9: low address bits ignored
    cpu_wr(11'h02B, 32'h00A5A5A5);
    model[10] = keep(32'h00A5A5A5);
    cpu_rd(11'h028, r);
    check("R9 low bits alias", r, model[10]);
    drop_grant();

    // R6: ungranted read returns zero
    cpu_rd(11'h01C, r);
    check("R6 ungranted read zero", r, 32'h0);
    // R5: ungranted write ignored
    cpu_wr(11'h014, 32'h00123456);
    // R7: random display reads
    for (int k = 0; k < 40; k++) begin
      int i = $urandom_range(255);
      pix(i[7:0], d, v);
      check("R7 col_valid", {31'b0, v}, 32'h1);
      check("R7 col_data", d, model[i]);
    end
    pix(8'd5, d, v);
    check("R5 display sees old entry", d, model[5]);
    @(negedge clk);
    check("R7 col_valid low", {31'b0, col_valid}, 32'h0);

    // R8: hold while granted
    pix(8'd7, last, v);
    get_grant();
    for (int k = 0; k < 10; k++) begin
      int i = $urandom_range(255);
      pix(i[7:0], d, v);
      check("R8 colour held", d, last);
    end
    cpu_rd(11'h014, r);
    check("R5 entry unchanged", r, model[5]);
    drop_grant();
    pix(8'd10, d, v);
    check("R7 live after release", d, model[10]);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule